// File: doc/BRIEF.md
# Serial Control Register Access Master

This block is a bus master that reads and writes 16-bit registers in an audio decoder over a four-wire serial control link. The four wires are an active-low select, a serial clock, a master-to-slave data line and a slave-to-master data line. A host raises a one-cycle request that carries a read/write flag, an 8-bit register address and, for writes, a 16-bit data word. The block then runs one complete transaction on the serial wires and reports its end with a one-cycle `done` pulse. For reads, the captured word is presented on `rd_data` in the same cycle as that pulse.

Every transaction is a fixed 32-bit frame made of four bytes. The frame starts with a command byte, which is 0x02 for a write and 0x03 for a read; both values are parameters. The register address follows. The last 16 bits carry the data word. On a write the master sends those 16 bits. On a read the master holds its output low during those 16 bits and captures the word that the slave shifts back. The serial clock period is `SCK_DIV` system clocks, split evenly into a low half and a high half. The serial clock idles low.

Top module: `sctl_reg_master`

## Requirements
- R1: After reset, `sc_cs_n` is 1, `sc_clk` is 0, `sc_mosi` is 0, and `busy`, `done` and `rd_data` are all 0.
- R2: A request (`req_valid` high while `busy` is low) is accepted on a clock edge. From that edge, `busy` is high and `sc_cs_n` is low until the cycle in which `done` pulses, when `busy` returns low.
- R3: `sc_clk` is low whenever `sc_cs_n` is high. Within a frame, each serial clock period is `SCK_DIV` system clocks: `SCK_DIV/2` low, then `SCK_DIV/2` high. Every frame has exactly 32 rising edges, and the first rising edge comes `SCK_DIV/2` cycles after select goes low.
- R4: Each byte is sent most significant bit first. `sc_mosi` changes only while `sc_clk` is low, so it is stable across each rising edge where the slave samples it.
- R5: A write frame carries, in order, 0x02, then the address, then `req_wdata[15:8]`, then `req_wdata[7:0]`.
- R6: A read frame carries 0x03 and then the address. `sc_mosi` is held at 0 for the remaining 16 bits.
- R7: On a read, `sc_miso` is sampled on rising edges 17 to 32. The first of these bits becomes `rd_data[15]` and the last becomes `rd_data[0]`. `rd_data` is updated in the cycle that `done` pulses.
- R8: `done` is a single-cycle pulse. It rises in the same cycle that `sc_cs_n` returns high, which is `SCK_DIV/2` cycles after the last falling edge. Done is therefore 65·`SCK_DIV/2` cycles after the accepting edge.
- R9: A request that arrives while `busy` is high is ignored. No extra frame is started, and the frame in progress is not altered.
- R10: A write leaves `rd_data` holding the result of the previous read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data word |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_data | output | 16 | Word captured by the most recent read |
| sc_cs_n | output | 1 | Active-low select for the serial slave |
| sc_clk | output | 1 | Serial clock, idles low |
| sc_mosi | output | 1 | Data from master to slave |
| sc_miso | input | 1 | Data from slave to master |

## Verification
Two situations are hard to bring about from the ports. The first is the turnaround inside a read: the slave must start driving on the sixteenth falling edge, and the master must sample that bit a half period later. The bench's slave model decodes the command and address from its own rising-edge samples and begins driving on exactly that edge, so any misplaced sample point shifts the returned word. The second is a request that overlaps a running frame. The bench holds a second, different request high for many cycles in the middle of a write, then checks that the slave saw exactly one frame and that it carried the original contents.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int SCTL_OP_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TAIL = 2'd3
  } sctl_state_e;

  // Half period of the serial clock, in system clocks
  function automatic int sctl_half(input int sck_div);
    return (sck_div < 2) ? 1 : sck_div / 2;
  endfunction

  // System clocks from the accepting edge to the done pulse
  function automatic int sctl_frame_cycles(input int half, input int bits);
    return (2 * bits + 1) * half;
  endfunction

  // Command byte for a request
  function automatic logic [SCTL_OP_W-1:0] sctl_pick_op(
    input logic                 rd,
    input logic [SCTL_OP_W-1:0] wr_op,
    input logic [SCTL_OP_W-1:0] rd_op
  );
    return rd ? rd_op : wr_op;
  endfunction

endpackage

// File: rtl/sctl_phase_timer.sv
module sctl_phase_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);

  generate
    if (HALF_CYC <= 1) begin : g_direct
      assign phase_end = run;
    end else begin : g_count
      localparam int CNT_W = $clog2(HALF_CYC);
      localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_CYC - 1);
      logic [CNT_W-1:0] ph;

      assign phase_end = run && (ph == TOP);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ph <= '0;
        end else if (!run || phase_end) begin
          ph <= '0;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sctl_seq.sv
module sctl_seq
  import sctl_pkg::*;
#(
  parameter int FRAME_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        phase_end,
  output sctl_state_e state,
  output logic        cs_n,
  output logic        sclk,
  output logic        done,
  output logic        rise_evt,
  output logic        fall_evt,
  output logic        finish_evt
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  logic [BIT_W-1:0] bitcnt;
  logic             last_bit;

  assign last_bit   = (bitcnt == LAST_BIT);
  assign rise_evt   = (state == ST_LOW)  && phase_end;
  assign fall_evt   = (state == ST_HIGH) && phase_end && !last_bit;
  assign finish_evt = (state == ST_TAIL) && phase_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      done   <= 1'b0;
      bitcnt <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_LOW;
            cs_n   <= 1'b0;
            bitcnt <= '0;
          end
        end
        ST_LOW: begin
          if (phase_end) begin
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (phase_end) begin
            sclk <= 1'b0;
            if (last_bit) begin
              state <= ST_TAIL;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              state  <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (phase_end) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sctl_tx_shift.sv
module sctl_tx_shift #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  input  logic               clear,
  output logic               mosi
);

  logic [FRAME_W-1:0] sr;

  assign mosi = sr[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (load) begin
      sr <= frame;
    end else if (clear) begin
      sr <= '0;
    end else if (shift) begin
      sr <= {sr[FRAME_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/sctl_rx_capture.sv
module sctl_rx_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic              sample,
  input  logic              miso,
  input  logic              finish,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] rx;
  logic              is_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx      <= '0;
      is_rd   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (start) begin
        is_rd <= start_rd;
      end
      if (sample) begin
        rx <= {rx[DATA_W-2:0], miso};
      end
      if (finish && is_rd) begin
        rd_data <= rx;
      end
    end
  end

endmodule

// File: rtl/sctl_reg_master.sv
module sctl_reg_master
  import sctl_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 16,
  parameter int          SCK_DIV = 4,
  parameter logic [7:0]  WR_OP   = 8'h02,
  parameter logic [7:0]  RD_OP   = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              sc_cs_n,
  output logic              sc_clk,
  output logic              sc_mosi,
  input  logic              sc_miso
);

  localparam int HALF_CYC = sctl_half(SCK_DIV);
  localparam int FRAME_W  = SCTL_OP_W + ADDR_W + DATA_W;

  sctl_state_e        state;
  logic               start_evt;
  logic               phase_end;
  logic               rise_evt;
  logic               fall_evt;
  logic               finish_evt;
  logic [FRAME_W-1:0] frame_word;

  assign busy      = (state != ST_IDLE);
  assign start_evt = req_valid && !busy;
  assign frame_word = {sctl_pick_op(req_rd, WR_OP, RD_OP), req_addr,
                       req_rd ? {DATA_W{1'b0}} : req_wdata};

  sctl_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .phase_end (phase_end)
  );

  sctl_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .phase_end  (phase_end),
    .state      (state),
    .cs_n       (sc_cs_n),
    .sclk       (sc_clk),
    .done       (done),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .finish_evt (finish_evt)
  );

  sctl_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_evt),
    .frame (frame_word),
    .shift (fall_evt),
    .clear (finish_evt),
    .mosi  (sc_mosi)
  );

  sctl_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .start_rd (req_rd),
    .sample   (rise_evt),
    .miso     (sc_miso),
    .finish   (finish_evt),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/sctl_reg_master_chk.sv
module sctl_reg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sc_cs_n,
  input logic sc_clk,
  input logic sc_mosi,
  input logic rise_evt,
  input logic fall_evt,
  input logic finish_evt
);

  // R3
  cs_idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_cs_n |-> !sc_clk);

  // R3
  rise_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_clk) |-> (!sc_cs_n && $past(!sc_cs_n)));

  // R3
  rise_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (busy && !sc_clk));

  // R3
  fall_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> sc_clk);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_clk && $past(sc_clk)) |-> $stable(sc_mosi));

  // R2
  busy_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sc_cs_n);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sc_cs_n && $past(!sc_cs_n)));

  // R8
  finish_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |-> (!sc_clk && !sc_cs_n));

endmodule

bind sctl_reg_master sctl_reg_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .sc_cs_n    (sc_cs_n),
  .sc_clk     (sc_clk),
  .sc_mosi    (sc_mosi),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .finish_evt (finish_evt)
);

// File: tb/tb_sctl_reg_master.sv
`timescale 1ns/1ps
module tb_sctl_reg_master;

  localparam int SCK_DIV = 4;
  localparam int HALF    = SCK_DIV / 2;
  localparam int FRAME_CYC = 65 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_rd = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done;
  logic [15:0] rd_data;
  logic        sc_cs_n, sc_clk, sc_mosi;
  logic        sc_miso = 1'b0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sctl_reg_master #(.SCK_DIV(SCK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .sc_cs_n(sc_cs_n), .sc_clk(sc_clk),
    .sc_mosi(sc_mosi), .sc_miso(sc_miso)
  );

  // ---------------- slave model ----------------
  logic [15:0] smem [16];
  logic [31:0] s_shift = '0;
  logic [31:0] s_last  = '0;
  int          s_cnt   = 0;
  int          s_rises_last = 0;
  int          s_frames = 0;
  logic        s_rd    = 1'b0;
  logic [15:0] s_word  = '0;

  always @(posedge sc_clk) begin
    if (!sc_cs_n) begin
      s_shift = {s_shift[30:0], sc_mosi};
      s_cnt   = s_cnt + 1;
    end
  end

  always @(negedge sc_clk) begin
    if (!sc_cs_n) begin
      if (s_cnt == 16) begin
        s_rd   = (s_shift[15:8] == 8'h03);
        s_word = smem[s_shift[3:0]];
      end
      if (s_rd && s_cnt >= 16 && s_cnt < 32) sc_miso <= s_word[31 - s_cnt];
      else sc_miso <= 1'b0;
    end
  end

  always @(posedge sc_cs_n) begin
    if (s_cnt > 0) begin
      s_last       = s_shift;
      s_rises_last = s_cnt;
      s_frames     = s_frames + 1;
      if (s_shift[31:24] == 8'h02) smem[s_shift[19:16]] = s_shift[15:0];
    end
    s_cnt   = 0;
    s_rd    = 1'b0;
    sc_miso <= 1'b0;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  int last_cyc;
  int last_hi;

  // Issue a request and wait for done; measures cycles and sclk-high time
  task automatic do_txn(input bit rd, input logic [7:0] a, input logic [15:0] d);
    int n;
    int hi;
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; hi = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      if (sc_clk) hi++;
    end
    last_cyc = n - 1;
    last_hi  = hi;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    check(sc_cs_n == 1'b1, "R1 cs_n", 32'(sc_cs_n), 32'd1);
    check(sc_clk == 1'b0 && sc_mosi == 1'b0, "R1 clk/mosi",
          {30'd0, sc_clk, sc_mosi}, 32'd0);
    check(!busy && !done, "R1 busy/done", {30'd0, busy, done}, 32'd0);
    check(rd_data == 16'h0, "R1 rd_data", 32'(rd_data), 32'd0);
  endtask

  task automatic t_write(input logic [7:0] a, input logic [15:0] d);
    int f0;
    f0 = s_frames;
    do_txn(1'b0, a, d);
    check(s_frames == f0 + 1, "R2 one frame per request", 32'(s_frames), 32'(f0 + 1));
    check(s_last == {8'h02, a, d}, "R5 R4 write frame msb first", s_last, {8'h02, a, d});
    check(s_rises_last == 32, "R3 rising edges per frame", 32'(s_rises_last), 32'd32);
    check(last_hi == 32 * HALF, "R3 clock high time", 32'(last_hi), 32'(32 * HALF));
    check(last_cyc == FRAME_CYC, "R8 accept-to-done cycles", 32'(last_cyc), 32'(FRAME_CYC));
    @(negedge clk);
    check(!done && sc_cs_n && !busy, "R8 done single pulse",
          {29'd0, done, sc_cs_n, busy}, 32'd2);
  endtask

  task automatic t_read(input logic [7:0] a, input logic [15:0] exp);
    do_txn(1'b1, a, 16'hFFFF);
    check(s_last[31:16] == {8'h03, a}, "R6 read command/address",
          32'(s_last[31:16]), 32'({8'h03, a}));
    check(s_last[15:0] == 16'h0, "R6 mosi low in data phase", 32'(s_last[15:0]), 32'd0);
    check(rd_data == exp, "R7 read word", 32'(rd_data), 32'(exp));
    check(last_cyc == FRAME_CYC, "R8 read cycles", 32'(last_cyc), 32'(FRAME_CYC));
  endtask

  task automatic t_busy_ignore();
    int f0;
    int n;
    f0 = s_frames;
    @(negedge clk);
    req_valid = 1'b1; req_rd = 1'b0; req_addr = 8'h05; req_wdata = 16'h1357;
    @(negedge clk);
    req_addr = 8'h09; req_wdata = 16'hFFFF; req_rd = 1'b1;
    repeat (40) @(negedge clk);
    check(busy && !sc_cs_n, "R2 busy while frame runs", {30'd0, busy, sc_cs_n}, 32'd2);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    check(s_frames == f0 + 1, "R9 overlapping request ignored", 32'(s_frames), 32'(f0 + 1));
    check(s_last == {8'h02, 8'h05, 16'h1357}, "R9 frame unaltered", s_last,
          {8'h02, 8'h05, 16'h1357});
    check(!busy && sc_cs_n, "R9 no restart", {30'd0, busy, sc_cs_n}, 32'd1);
  endtask

  task automatic t_write_keeps_rd();
    logic [15:0] held;
    held = rd_data;
    do_txn(1'b0, 8'h0C, 16'h0F0F);
    check(rd_data == held, "R10 write keeps rd_data", 32'(rd_data), 32'(held));
  endtask

  // ---------------- main ----------------
  initial begin
    for (int i = 0; i < 16; i++) smem[i] = 16'hA500 ^ (16'(i) * 16'h1111);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_write(8'h03, 16'hBEEF);
    t_write(8'h0A, 16'h8001);
    t_read(8'h03, 16'hBEEF);
    t_read(8'h07, 16'hA500 ^ (16'd7 * 16'h1111));
    t_read(8'h0A, 16'h8001);
    t_busy_ignore();
    t_read(8'h05, 16'h1357);
    t_write_keeps_rd();
    t_read(8'h0C, 16'h0F0F);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog expired (R2 transaction never completed)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule